// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is the DMA front end of a keyed configuration store. Firmware puts a 16-byte descriptor in memory and writes the descriptor's 64-bit physical address into a doorbell register. The engine then reads the descriptor and optionally switches the store to a new key. It then copies the item's bytes into memory, or steps over them, and finally writes a completion word back over the descriptor's control field. Reading the engine's register window returns a fixed 64-bit signature, so software can tell that the engine is present.

The descriptor holds a 32-bit control word at byte 0, a 32-bit length at byte 4 and a 64-bit target address at byte 8, all big-endian. The control bits are: bit 0 error, bit 1 read, bit 2 skip, bit 3 select, and bits 31:16 the key to select. The item store is reached through a byte port, which reports the bytes left at the current offset and moves that offset forward by one byte per pull. Memory is reached through a request/response port with one request outstanding.

The control sequence runs through these states. IDLE goes to FETCH_REQ on an accepted doorbell. FETCH_REQ goes to FETCH_WAIT. FETCH_WAIT returns to FETCH_REQ until the fourth word arrives. After the fourth word it goes to SELECT when bit 3 is set and to MOVE otherwise, and on a fetch error it goes to STATUS_REQ. SELECT goes to MOVE. MOVE goes to STATUS_REQ when the length is zero, to MOVE_WAIT for each read byte, and stays in MOVE while skipping. MOVE_WAIT returns to MOVE on a good response and goes to STATUS_REQ on an error. STATUS_REQ goes to STATUS_WAIT, and STATUS_WAIT returns to IDLE when the response arrives.

Top module: `cfg_dma_engine`

## Requirements
- R1: `reg_rd_data` returns `reg_rd_bytes` bytes (1 to 8) of the value 0x51454D5520434647, counted from its most significant byte and starting at byte `reg_rd_off`, right-aligned. For example, 4 bytes at offset 4 give 0x20434647.
- R2: Three register writes are accepted. A 32-bit write (`reg_wr_wide`=0) at offset 0 stores the high address half and starts nothing. A 32-bit write at offset 4 supplies the low half and starts a transfer. A 64-bit write (`reg_wr_wide`=1) at offset 0 supplies the whole address and starts a transfer. Any other write changes nothing and starts nothing.
- R3: The stored high address half is cleared when a transfer starts, so a later low-half-only doorbell fetches from an address whose upper 32 bits are zero.
- R4: A doorbell written while `busy` is high is ignored: no second transfer and no second `done`.
- R5: The descriptor is fetched as four 32-bit reads at base+0, +4, +8 and +12, one request at a time. `mem_rdata[31:24]` is the byte at the lowest address.
- R6: When control bit 3 is set, `item_sel` pulses once with `item_key` equal to control bits 31:16 before any data moves.
- R7: With control bit 1 set, the engine does `length` single-byte writes to consecutive addresses from the target address. Each byte is the next item byte while `item_left` is non-zero and zero after that.
- R8: With bit 1 clear and bit 2 set, the engine pulls min(length, `item_left`) item bytes and writes no memory.
- R9: With bits 1 and 2 both clear, no item byte is pulled, no data is written and the status is 0.
- R10: If a descriptor read returns an error, the status word 0x00000001 is written at the base address, with no select and no data writes.
- R11: If a data byte write returns an error, the transfer stops after that byte and the status is 0x00000001. A byte whose write failed has still been pulled from the item.
- R12: The status is one 32-bit write at the base address: 0x00000000 on success, 0x00000001 on error. `done` pulses for one cycle with its response. `busy` is high from the cycle after the starting doorbell until after `done`, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_off | input | 3 | Byte offset of the write |
| reg_wr_wide | input | 1 | 1: 64-bit write, 0: 32-bit write |
| reg_wr_data | input | 64 | Write data; 32-bit writes use bits 31:0 |
| reg_rd_off | input | 3 | Byte offset of a window read |
| reg_rd_bytes | input | 4 | Size of a window read in bytes |
| reg_rd_data | output | 64 | Signature bytes, right-aligned |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1: write, 0: read |
| mem_word | output | 1 | 1: 32-bit access, 0: single byte |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 32 | Write data; a byte write uses bits 7:0 |
| mem_rsp | input | 1 | Response strobe |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data, big-endian |
| item_sel | output | 1 | Select pulse to the item store |
| item_key | output | 16 | Key to select |
| item_rd | output | 1 | Pull one item byte |
| item_byte | input | 8 | Item byte at the current offset |
| item_left | input | 32 | Item bytes left at the current offset |

## Verification
The bench builds the engine with its default parameters: 64-bit addresses, 32-bit lengths and 16-bit keys. With these values the split doorbell and the clearing of its high half can be exercised. It also writes descriptors and targets above 4 GiB, and uses keys that land outside the modelled store to test invalid and empty items. The bench's item store gives key k a length of k[4:0] for keys below 0x40, which places item ends inside, at and before the requested lengths. A memory model with random latency checks the one-request-at-a-time fetch order and lets the bench inject a fault at a chosen byte.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    localparam int WORD_W     = 32;
    localparam int CTL_ERR    = 0;
    localparam int CTL_READ   = 1;
    localparam int CTL_SKIP   = 2;
    localparam int CTL_SELECT = 3;
    localparam int KEY_LSB    = 16;
    localparam logic [63:0] SIGNATURE = 64'h5145_4D55_2043_4647;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_REQ,
        S_FETCH_WAIT,
        S_SELECT,
        S_MOVE,
        S_MOVE_WAIT,
        S_STATUS_REQ,
        S_STATUS_WAIT
    } dma_state_e;

endpackage

// File: rtl/cfg_dma_doorbell.sv
module cfg_dma_doorbell #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        off,
    input  logic              wide,
    input  logic [ADDR_W-1:0] data,
    input  logic              busy,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int HALF_W = ADDR_W / 2;

    logic [HALF_W-1:0] hi_q;
    logic hit_hi, hit_lo, hit_full;

    // Only three write shapes are decoded; everything else falls through.
    assign hit_hi   = wr && !wide && (off == 3'd0);
    assign hit_lo   = wr && !wide && (off == 3'd4);
    assign hit_full = wr &&  wide && (off == 3'd0);

    assign start      = !busy && (hit_lo || hit_full);
    assign start_addr = hit_full ? data : {hi_q, data[HALF_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (start) begin
            hi_q <= '0;
        end else if (!busy && hit_hi) begin
            hi_q <= data[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/cfg_dma_sig.sv
module cfg_dma_sig
    import cfg_dma_pkg::*;
(
    input  logic [2:0]  off,
    input  logic [3:0]  nbytes,
    output logic [63:0] data
);
    logic [6:0] lsh, rsh;

    assign lsh = {1'b0, off, 3'b000};
    assign rsh = 7'd64 - {nbytes, 3'b000};

    always_comb begin
        if (nbytes == 4'd0 || nbytes > 4'd8) data = '0;
        else                                 data = (SIGNATURE << lsh) >> rsh;
    end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
    import cfg_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32,
    parameter int KEY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_wr_off,
    input  logic              reg_wr_wide,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic [2:0]        reg_rd_off,
    input  logic [3:0]        reg_rd_bytes,
    output logic [63:0]       reg_rd_data,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rsp,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              item_sel,
    output logic [KEY_W-1:0]  item_key,
    output logic              item_rd,
    input  logic [7:0]        item_byte,
    input  logic [LEN_W-1:0]  item_left
);
    localparam int HALF_W = ADDR_W / 2;

    dma_state_e        state, state_nx;
    logic [ADDR_W-1:0] base_q, cur_q, db_addr;
    logic [WORD_W-1:0] ctl_q;
    logic [LEN_W-1:0]  rem_q;
    logic [1:0]        fidx_q;
    logic              err_q, db_start, is_read, is_skip, have_byte;

    cfg_dma_doorbell #(.ADDR_W(ADDR_W)) u_doorbell (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .off(reg_wr_off),
        .wide(reg_wr_wide), .data(reg_wr_data), .busy(busy),
        .start(db_start), .start_addr(db_addr)
    );

    cfg_dma_sig u_sig (.off(reg_rd_off), .nbytes(reg_rd_bytes), .data(reg_rd_data));

    assign is_read   = ctl_q[CTL_READ];
    assign is_skip   = !ctl_q[CTL_READ] && ctl_q[CTL_SKIP];
    assign have_byte = (item_left != '0);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:        if (db_start) state_nx = S_FETCH_REQ;
            S_FETCH_REQ:   state_nx = S_FETCH_WAIT;
            S_FETCH_WAIT:  if (mem_rsp) begin
                               if (mem_rsp_err)          state_nx = S_STATUS_REQ;
                               else if (fidx_q != 2'd3)  state_nx = S_FETCH_REQ;
                               else if (ctl_q[CTL_SELECT]) state_nx = S_SELECT;
                               else                      state_nx = S_MOVE;
                           end
            S_SELECT:      state_nx = S_MOVE;
            S_MOVE:        if (rem_q == '0)  state_nx = S_STATUS_REQ;
                           else if (is_read) state_nx = S_MOVE_WAIT;
            S_MOVE_WAIT:   if (mem_rsp) state_nx = mem_rsp_err ? S_STATUS_REQ : S_MOVE;
            S_STATUS_REQ:  state_nx = S_STATUS_WAIT;
            S_STATUS_WAIT: if (mem_rsp) state_nx = S_IDLE;
            default:       state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Descriptor and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0; cur_q <= '0; ctl_q <= '0;
            rem_q  <= '0; fidx_q <= '0; err_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (db_start) begin
                    base_q <= db_addr;
                    fidx_q <= '0;
                    err_q  <= 1'b0;
                    ctl_q  <= '0;
                end
                S_FETCH_WAIT: if (mem_rsp) begin
                    if (mem_rsp_err) begin
                        err_q <= 1'b1;
                    end else begin
                        unique case (fidx_q)
                            2'd0:    ctl_q <= mem_rdata;
                            2'd1:    rem_q <= mem_rdata[LEN_W-1:0];
                            2'd2:    cur_q[ADDR_W-1:HALF_W] <= mem_rdata;
                            default: cur_q[HALF_W-1:0] <= mem_rdata;
                        endcase
                        fidx_q <= fidx_q + 2'd1;
                        // Neither read nor skip: nothing moves.
                        if (fidx_q == 2'd3 && !ctl_q[CTL_READ] && !ctl_q[CTL_SKIP])
                            rem_q <= '0;
                    end
                end
                S_MOVE: if (rem_q != '0 && !is_read) begin
                    // A skip past the item end consumes all that is left at once.
                    if (!have_byte) rem_q <= '0;
                    else            rem_q <= rem_q - 1'b1;
                end
                S_MOVE_WAIT: if (mem_rsp) begin
                    if (mem_rsp_err) begin
                        err_q <= 1'b1;
                    end else begin
                        rem_q <= rem_q - 1'b1;
                        cur_q <= cur_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b1;
        mem_addr  = base_q;
        mem_wdata = '0;
        item_sel  = 1'b0;
        item_rd   = 1'b0;
        unique case (state)
            S_FETCH_REQ: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'({fidx_q, 2'b00});
            end
            S_SELECT: item_sel = 1'b1;
            S_MOVE: if (rem_q != '0) begin
                item_rd = have_byte && (is_read || is_skip);
                if (is_read) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_word  = 1'b0;
                    mem_addr  = cur_q;
                    mem_wdata = {{(WORD_W-8){1'b0}}, have_byte ? item_byte : 8'h00};
                end
            end
            S_STATUS_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {{(WORD_W-1){1'b0}}, err_q};
            end
            default: ;
        endcase
    end

    assign item_key = ctl_q[KEY_LSB +: KEY_W];
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_STATUS_WAIT) && mem_rsp;

endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic             item_sel,
    input logic             item_rd,
    input logic [LEN_W-1:0] item_left
);
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R12

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R5

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R12

    AST_NO_PULL_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        item_rd |-> (item_left != '0)); // R7

    AST_START_BY_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr)); // R2

    AST_SELECT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        item_sel |-> (busy && !mem_req && !item_rd)); // R6
endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .busy(busy), .done(done),
    .mem_req(mem_req), .item_sel(item_sel), .item_rd(item_rd), .item_left(item_left)
);

// File: tb/cfg_dma_engine_test.sv
`timescale 1ns/1ps
module cfg_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_wr_off = '0;
    logic        reg_wr_wide = 1'b0;
    logic [63:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_off = '0;
    logic [3:0]  reg_rd_bytes = '0;
    logic [63:0] reg_rd_data;
    logic        busy, done, mem_req, mem_we, mem_word;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rsp = 1'b0, mem_rsp_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        item_sel, item_rd;
    logic [15:0] item_key;
    logic [7:0]  item_byte;
    logic [31:0] item_left;

    always #4 clk = ~clk;

    cfg_dma_engine uut (.*);

    int n_chk = 0, n_fail = 0;

    // ---------------- item store model ----------------
    logic [15:0] st_key;
    logic [31:0] st_off;

    function automatic logic [31:0] ilen(input logic [15:0] k);
        return (k < 16'h40) ? {27'b0, k[4:0]} : 32'd0;
    endfunction
    function automatic logic [7:0] ibyte(input logic [15:0] k, input logic [31:0] o);
        return k[7:0] * 8'd7 + o[7:0] * 8'd13 + 8'd1;
    endfunction

    assign item_left = (st_off < ilen(st_key)) ? ilen(st_key) - st_off : 32'd0;
    assign item_byte = ibyte(st_key, st_off);

    always @(posedge clk) begin
        if (!rst_n) begin
            st_key <= '0; st_off <= '0;
        end else if (item_sel) begin
            st_key <= item_key; st_off <= '0;
        end else if (item_rd) begin
            st_off <= st_off + 1;
        end
    end

    // ---------------- memory model ----------------
    bit [7:0] mem [bit [63:0]];
    logic [63:0] fault_addr = '0;
    logic        fault_on = 1'b0;
    logic        pend = 1'b0, p_we = 1'b0, p_word = 1'b0, err_l;
    logic [63:0] p_addr = '0;
    logic [31:0] p_wd = '0;
    int          lat = 0, byte_wr_cnt = 0, rd_idx = 0, done_cnt = 0;
    logic [63:0] first_rd_addr = '0;

    always @(posedge clk) begin
        mem_rsp <= 1'b0;
        if (done) begin done_cnt <= done_cnt + 1; rd_idx <= 0; end
        if (mem_req) begin
            pend <= 1'b1; p_addr <= mem_addr; p_we <= mem_we;
            p_word <= mem_word; p_wd <= mem_wdata;
            lat <= $urandom_range(0, 2);
            if (!mem_we) begin
                if (rd_idx == 0) first_rd_addr <= mem_addr;
                rd_idx <= rd_idx + 1;
            end
        end else if (pend) begin
            if (lat == 0) begin
                pend <= 1'b0;
                mem_rsp <= 1'b1;
                err_l = fault_on && (p_addr == fault_addr);
                mem_rsp_err <= err_l;
                if (!err_l) begin
                    if (p_we && p_word) begin
                        mem[p_addr]   = p_wd[31:24]; mem[p_addr+1] = p_wd[23:16];
                        mem[p_addr+2] = p_wd[15:8];  mem[p_addr+3] = p_wd[7:0];
                    end else if (p_we) begin
                        mem[p_addr] = p_wd[7:0];
                        byte_wr_cnt <= byte_wr_cnt + 1;
                    end else begin
                        mem_rdata <= {mem[p_addr], mem[p_addr+1], mem[p_addr+2], mem[p_addr+3]};
                    end
                end
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put32(input logic [63:0] a, input logic [31:0] v);
        mem[a] = v[31:24]; mem[a+1] = v[23:16]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0];
    endtask

    task automatic db_write(input logic [2:0] off, input logic wide, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wr_off = off; reg_wr_wide = wide; reg_wr_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic sig_rd(input logic [2:0] off, input logic [3:0] n, input logic [63:0] exp);
        @(negedge clk);
        reg_rd_off = off; reg_rd_bytes = n;
        #1;
        chk("R1", "signature read", reg_rd_data, exp);
    endtask

    logic [15:0] m_key = '0;
    logic [31:0] m_off = '0;

    // how: 0 = 64-bit doorbell, 1 = split halves, 2 = low half only
    // fault: 0 none, 1 descriptor read at base+8, 2 data write at dst+k
    task automatic run_desc(input logic [63:0] base, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [63:0] dst,
                            input int fault, input int k, input int how, input bit poke);
        logic [7:0] exp [64];
        int exp_wr, d0, wr0, L;
        logic exp_err;
        logic [7:0] b;
        put32(base, ctl); put32(base + 4, len);
        put32(base + 8, dst[63:32]); put32(base + 12, dst[31:0]);
        for (int i = 0; i < 64; i++) begin exp[i] = 8'hA5; mem[dst + i] = 8'hA5; end
        fault_on   = (fault != 0);
        fault_addr = (fault == 1) ? base + 8 : dst + k;
        exp_wr = 0; exp_err = 1'b0;
        if (fault == 1) begin
            exp_err = 1'b1;
        end else begin
            if (ctl[3]) begin m_key = ctl[31:16]; m_off = 0; end
            L = ilen(m_key);
            if (ctl[1]) begin
                for (int i = 0; i < len; i++) begin
                    if (m_off < L) begin b = ibyte(m_key, m_off); m_off++; end
                    else b = 8'h00;
                    if (fault == 2 && i == k) begin exp_err = 1'b1; break; end
                    exp[i] = b; exp_wr++;
                end
            end else if (ctl[2]) begin
                if (m_off < L) m_off += (len < L - m_off) ? len : L - m_off;
            end
        end
        d0 = done_cnt; wr0 = byte_wr_cnt;
        if (how == 1) db_write(3'd0, 1'b0, {32'h0, base[63:32]});
        if (how == 0) db_write(3'd0, 1'b1, base);
        else          db_write(3'd4, 1'b0, {32'h0, base[31:0]});
        chk("R12", "busy after doorbell", busy, 1'b1);
        if (poke) db_write(3'd0, 1'b1, 64'h1F00);
        while (done_cnt == d0) @(negedge clk);
        repeat (poke ? 12 : 1) @(negedge clk);
        chk("R12", "busy after done", busy, 1'b0);
        if (poke) chk("R4", "done pulses for one doorbell", done_cnt - d0, 1);
        chk("R5", "descriptor fetch address", first_rd_addr, base);
        chk(exp_err ? (fault == 1 ? "R10" : "R11") : "R12", "status word",
            {mem[base], mem[base+1], mem[base+2], mem[base+3]}, {63'b0, exp_err});
        chk(ctl[1] ? "R7" : "R8", "byte write count", byte_wr_cnt - wr0, exp_wr);
        for (int i = 0; i < len + 1 && i < 64; i++)
            chk(ctl[1] ? "R7" : "R9", "target byte", mem[dst + i], exp[i]);
        chk("R6", "selected key", st_key, m_key);
        chk(ctl[2] ? "R8" : "R7", "item offset", st_off, m_off);
        fault_on = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] ctl, len;
        logic [15:0] key;
        int fault, k;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk("R12", "reset busy", busy, 1'b0);
        chk("R12", "reset done", done, 1'b0);
        chk("R12", "reset mem_req", mem_req, 1'b0);
        rst_n = 1'b1;

        sig_rd(3'd0, 4'd8, 64'h5145_4D55_2043_4647);
        sig_rd(3'd4, 4'd4, 64'h2043_4647);
        sig_rd(3'd1, 4'd1, 64'h45);
        sig_rd(3'd6, 4'd2, 64'h4647);
        sig_rd(3'd0, 4'd4, 64'h5145_4D55);

        // R2: rejected write shapes start nothing
        db_write(3'd2, 1'b0, 64'h1000);
        db_write(3'd4, 1'b1, 64'h1000);
        db_write(3'd0, 1'b0, 64'h0);
        repeat (3) @(negedge clk);
        chk("R2", "rejected writes leave engine idle", busy, 1'b0);

        // R2 split doorbell above 4 GiB, select key 5, read 8
        run_desc(64'h1_0000_1000, {16'd5, 12'h0, 4'b1010}, 8, 64'h2_0000_8000, 0, 0, 1, 0);
        // R3 low-half-only doorbell: high half was cleared at start; R9 no mode bits
        run_desc(64'h0000_1100, {16'd9, 12'h0, 4'b0000}, 6, 64'h8100, 0, 0, 2, 0);
        // R8 skip 5 of key 20, then read 6 continuing from offset 5
        run_desc(64'h1200, {16'd20, 12'h0, 4'b1100}, 5, 64'h8200, 0, 0, 0, 0);
        run_desc(64'h1300, {16'd0, 12'h0, 4'b0010}, 6, 64'h8300, 0, 0, 0, 0);
        // R7 past end zero fill (key 3 has 3 bytes)
        run_desc(64'h1400, {16'd3, 12'h0, 4'b1010}, 10, 64'h8400, 0, 0, 0, 0);
        // R7 empty key
        run_desc(64'h1500, {16'h50, 12'h0, 4'b1010}, 4, 64'h8500, 0, 0, 0, 0);
        // R10 descriptor fetch error
        run_desc(64'h1600, {16'd7, 12'h0, 4'b1010}, 4, 64'h8600, 1, 0, 0, 0);
        // R11 write error on fourth byte
        run_desc(64'h1700, {16'd12, 12'h0, 4'b1010}, 10, 64'h8700, 2, 3, 0, 0);
        // R4 doorbell while busy is ignored
        run_desc(64'h1800, {16'd30, 12'h0, 4'b1010}, 30, 64'h8800, 0, 0, 0, 1);

        for (int i = 0; i < 40; i++) begin
            key = 16'($urandom_range(0, 16'h47));
            ctl = {key, 12'h0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b0};
            len = $urandom_range(0, 40);
            fault = 0; k = 0;
            if ($urandom_range(0, 15) == 0) fault = 1;
            else if (ctl[1] && len > 0 && $urandom_range(0, 7) == 0) begin
                fault = 2; k = $urandom_range(0, len - 1);
            end
            run_desc(64'h1_0000_2000 + 64'(i) * 16, ctl, len,
                     64'h3_0000_0000 + 64'(i) * 64, fault, k, i % 2, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule